// File: doc/BRIEF.md
# Sized Shifter with Condition Flags

This unit shifts an operand left or right by a variable count. It works at one of three operand widths: a quarter, a half or all of the datapath width, called byte, word and long. The shifted value is produced combinationally. It is meant for the execute stage of a CPU datapath that keeps negative, zero, overflow, carry and extend condition codes.

The shift can be logical or arithmetic in either direction. A left arithmetic shift detects signed overflow. Counts larger than the operand width are handled: the result collapses to zero or to sign fill, and the carry and extend outputs take the values the requirements define.

The caller supplies the current carry and extend flags, so that a zero count can pass them through unchanged. The five computed flags go into a flag register only in cycles where the update strobe is high.

Top module: `shift_flag_unit`

## Requirements
- R1: The count input is CNT_W bits wide (6 by default), and every value from 0 to 2^CNT_W-1 is legal at every width. Counts beyond the width follow R5, R6 and R7.
- R2: The size code on `size_i` selects the width: 0 = DATA_W/4, 1 = DATA_W/2, 2 or 3 = DATA_W. Operand bits above the width are ignored, and result bits above the width are driven to 0.
- R3: With a count of zero, the result equals the width-limited operand, V is 0, and C and X are copied from `c_i` and `x_i`.
- R4: A left shift (`left_i`=1) by n with 0<n<W gives the operand shifted up by n, with zeros filling from the bottom, and C equal to operand bit W-n. Logical and arithmetic left shifts give the same result.
- R5: A left shift by exactly W gives result 0 and C equal to operand bit 0. A left shift by more than W gives result 0 and C equal to 0.
- R6: A logical right shift (`left_i`=0, `logical_i`=1) by 0<n<W fills with zeros from the top, and C is operand bit n-1. For n=W the result is 0 and C is operand bit W-1. For n>W the result is 0 and C is 0.
- R7: An arithmetic right shift (`logical_i`=0) by 0<n<W fills with copies of bit W-1, and C is operand bit n-1. For n≥W every result bit equals bit W-1, and C equals bit W-1.
- R8: An arithmetic left shift sets V when its count n is nonzero and either of two conditions holds. For 0<n<W, the operand's top n+1 bits are neither all 0 nor all 1. For n≥W, the width-limited operand is nonzero.
- R9: Logical shifts in either direction, and arithmetic right shifts, always give V=0.
- R10: For a nonzero count, X equals the new C.
- R11: N is bit W-1 of the result, and Z is 1 exactly when the width-limited result is all zeros.
- R12: The flag outputs load the computed flags on a clock edge where `upd_i`=1, and hold their value otherwise. A synchronous active-high `rst` clears all five flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| opnd_i | input | DATA_W | Operand to shift |
| cnt_i | input | CNT_W | Shift count |
| size_i | input | 2 | Operand width code (0 byte, 1 word, 2/3 long) |
| left_i | input | 1 | 1 = shift left, 0 = shift right |
| logical_i | input | 1 | 1 = logical shift, 0 = arithmetic shift |
| c_i | input | 1 | Current carry flag, kept on a zero count |
| x_i | input | 1 | Current extend flag, kept on a zero count |
| upd_i | input | 1 | Flag register load strobe |
| res_o | output | DATA_W | Shifted result, zero above the selected width |
| n_o | output | 1 | Registered negative flag |
| z_o | output | 1 | Registered zero flag |
| v_o | output | 1 | Registered overflow flag |
| c_o | output | 1 | Registered carry flag |
| x_o | output | 1 | Registered extend flag |

## Verification
The bench builds the unit with DATA_W=8 and CNT_W=4. The three widths are then 2, 4 and 8 bits, and counts run from 0 to 15. Every operand value, every count, all four size codes, both directions and both shift types can be swept exhaustively in well under the cycle budget. At every width the sweep reaches the boundary counts (equal to the width, one above it, and far above it) and every sign pattern that decides overflow. Flag hold, reset clearing and the carry and extend pass-through on a zero count are each checked at the ports.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } shf_size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic x;
  } shf_flags_t;

  localparam int NUM_LANES = 3;

  // Lane index for a size code; code 3 aliases the full width.
  function automatic int lane_of(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_of = 0;
      SZ_WORD: lane_of = 1;
      default: lane_of = 2;
    endcase
  endfunction

endpackage

// File: rtl/shf_lane.sv
// One fixed-width shift lane: result, carry-out and left-arithmetic overflow.
module shf_lane #(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     opnd,
  input  logic [CNT_W-1:0] cnt,
  input  logic             left,
  input  logic             logical,
  output logic [W-1:0]     res,
  output logic             carry,
  output logic             ovf
);

  int               n;
  logic [W-1:0]     probe;
  logic [W-1:0]     run;
  logic             sgn;

  assign n   = int'(cnt);
  assign sgn = opnd[W-1];

  always_comb begin
    res   = opnd;
    carry = 1'b0;
    ovf   = 1'b0;
    probe = '0;
    run   = '0;
    if (n != 0) begin
      if (left) begin
        if (n < W) begin
          res   = opnd << n;
          probe = opnd >> (W - n);
          carry = probe[0];
          if (!logical) begin
            // Top n+1 bits collapsed by sign extension must be uniform.
            run = $signed(opnd) >>> (W - 1 - n);
            ovf = !((run == '0) || (run == '1));
          end
        end else begin
          res   = '0;
          carry = (n == W) ? opnd[0] : 1'b0;
          ovf   = !logical && (opnd != '0);
        end
      end else begin
        if (n < W) begin
          probe = opnd >> (n - 1);
          carry = probe[0];
          if (logical) res = opnd >> n;
          else         res = $signed(opnd) >>> n;
        end else if (logical) begin
          res   = '0;
          carry = (n == W) ? sgn : 1'b0;
        end else begin
          res   = {W{sgn}};
          carry = sgn;
        end
      end
    end
  end

endmodule

// File: rtl/shf_flag_calc.sv
// Chooses the active lane and forms the five condition flags.
module shf_flag_calc #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]     lane_res [shf_pkg::NUM_LANES],
  input  logic [shf_pkg::NUM_LANES-1:0] lane_msb,
  input  logic [shf_pkg::NUM_LANES-1:0] lane_carry,
  input  logic [shf_pkg::NUM_LANES-1:0] lane_ovf,
  input  logic [1:0]            size,
  input  logic                  cnt_nz,
  input  logic                  c_old,
  input  logic                  x_old,
  output logic [DATA_W-1:0]     res,
  output shf_pkg::shf_flags_t   flags
);
  import shf_pkg::*;

  int sel;
  assign sel = lane_of(size);

  always_comb begin
    res     = lane_res[sel];
    flags.n = lane_msb[sel];
    flags.z = (res == '0);
    flags.v = cnt_nz & lane_ovf[sel];
    flags.c = cnt_nz ? lane_carry[sel] : c_old;
    flags.x = cnt_nz ? lane_carry[sel] : x_old;
  end

endmodule

// File: rtl/shf_flag_reg.sv
// Flag register with load strobe and synchronous active-high reset.
module shf_flag_reg (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  shf_pkg::shf_flags_t d,
  output shf_pkg::shf_flags_t q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        size_i,
  input  logic              left_i,
  input  logic              logical_i,
  input  logic              c_i,
  input  logic              x_i,
  input  logic              upd_i,
  output logic [DATA_W-1:0] res_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              x_o
);
  import shf_pkg::*;

  logic [DATA_W-1:0]    lane_res [NUM_LANES];
  logic [NUM_LANES-1:0] lane_msb;
  logic [NUM_LANES-1:0] lane_carry;
  logic [NUM_LANES-1:0] lane_ovf;
  shf_flags_t           flags_d;
  shf_flags_t           flags_q;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int LW = DATA_W >> (NUM_LANES - 1 - k);
    logic [LW-1:0] r;
    shf_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
      .opnd    (opnd_i[LW-1:0]),
      .cnt     (cnt_i),
      .left    (left_i),
      .logical (logical_i),
      .res     (r),
      .carry   (lane_carry[k]),
      .ovf     (lane_ovf[k])
    );
    assign lane_res[k] = DATA_W'(r);
    assign lane_msb[k] = r[LW-1];
  end

  shf_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .lane_res   (lane_res),
    .lane_msb   (lane_msb),
    .lane_carry (lane_carry),
    .lane_ovf   (lane_ovf),
    .size       (size_i),
    .cnt_nz     (cnt_i != '0),
    .c_old      (c_i),
    .x_old      (x_i),
    .res        (res_o),
    .flags      (flags_d)
  );

  shf_flag_reg u_freg (
    .clk  (clk),
    .rst  (rst),
    .load (upd_i),
    .d    (flags_d),
    .q    (flags_q)
  );

  assign n_o = flags_q.n;
  assign z_o = flags_q.z;
  assign v_o = flags_q.v;
  assign c_o = flags_q.c;
  assign x_o = flags_q.x;

endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [1:0]        size_i,
  input logic              left_i,
  input logic              logical_i,
  input logic              c_i,
  input logic              x_i,
  input logic              upd_i,
  input logic [DATA_W-1:0] res_o,
  input logic              n_o,
  input logic              z_o,
  input logic              v_o,
  input logic              c_o,
  input logic              x_o
);
  localparam int BW = DATA_W / 4;

  // R2
  byte_confine_chk: assert property (@(posedge clk) disable iff (rst)
    (size_i == 2'd0) |-> (res_o[DATA_W-1:BW] == '0));

  // R3
  zero_count_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_i && cnt_i == '0) |=> (c_o == $past(c_i) && x_o == $past(x_i) && !v_o));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_i && (logical_i || !left_i)) |=> !v_o);

  // R10
  extend_follows_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_i && cnt_i != '0) |=> (x_o == c_o));

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> (z_o == ($past(res_o) == '0)));

  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> ($stable(n_o) && $stable(z_o) && $stable(v_o) && $stable(c_o) && $stable(x_o)));

endmodule

bind shift_flag_unit shift_flag_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_i(cnt_i), .size_i(size_i), .left_i(left_i),
  .logical_i(logical_i), .c_i(c_i), .x_i(x_i), .upd_i(upd_i), .res_o(res_o),
  .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o), .x_o(x_o)
);

// File: tb/shift_flag_unit_bench.sv
`timescale 1ns/1ps
module shift_flag_unit_bench;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] opnd;
  logic [CW-1:0] cnt;
  logic [1:0]    size;
  logic          left, logical, cin, xin, upd;
  logic [DW-1:0] res;
  logic          fn, fz, fv, fc, fx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  shift_flag_unit #(.DATA_W(DW), .CNT_W(CW)) u_shift_flag_unit (
    .clk(clk), .rst(rst), .opnd_i(opnd), .cnt_i(cnt), .size_i(size),
    .left_i(left), .logical_i(logical), .c_i(cin), .x_i(xin), .upd_i(upd),
    .res_o(res), .n_o(fn), .z_o(fz), .v_o(fv), .c_o(fc), .x_o(fx)
  );

  // Expected {result, n, z, v, c, x}, built bit by bit from the requirements.
  function automatic logic [DW+4:0] model(int sz, int lf, int lg, int a_in, int n,
                                          int ci, int xi);
    int w, a, r, c, v, x, top;
    w = (sz == 0) ? DW/4 : (sz == 1) ? DW/2 : DW;
    a = a_in & ((1 << w) - 1);
    top = (a >> (w-1)) & 1;
    r = 0; c = 0; v = 0;
    if (n == 0) begin
      r = a; c = ci;
    end else begin
      for (int i = 0; i < w; i++) begin
        int b;
        if (lf != 0)      b = (i - n >= 0) ? ((a >> (i - n)) & 1) : 0;
        else if (lg != 0) b = (i + n < w) ? ((a >> (i + n)) & 1) : 0;
        else              b = (i + n < w) ? ((a >> (i + n)) & 1) : top;
        r = r | (b << i);
      end
      if (lf != 0)      c = (n <= w) ? ((a >> (w - n)) & 1) : 0;
      else if (lg != 0) c = (n <= w) ? ((a >> (n - 1)) & 1) : 0;
      else              c = (n < w) ? ((a >> (n - 1)) & 1) : top;
      if (lf != 0 && lg == 0) begin
        if (n >= w) v = (a != 0) ? 1 : 0;
        else begin
          int ones = 0;
          for (int i = w - 1 - n; i < w; i++) ones += (a >> i) & 1;
          v = (ones != 0 && ones != n + 1) ? 1 : 0;
        end
      end
    end
    x = (n == 0) ? xi : c;
    model = {DW'(r), 1'((r >> (w-1)) & 1), 1'(r == 0), 1'(v), 1'(c), 1'(x)};
  endfunction

  task automatic check(input string req, input logic [DW+4:0] act, input logic [DW+4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (sz=%0d left=%0d logical=%0d opnd=%h cnt=%0d)",
               req, act, exp, size, left, logical, opnd, cnt);
    end
  endtask

  function automatic string req_of(int lf, int lg, int n, int w);
    if (n == 0) return "R3";
    if (n >= (1 << CW)) return "R1";
    if (lf != 0) return (n < w) ? "R4/R8" : "R5/R8";
    return (lg != 0) ? "R6/R9" : "R7/R9";
  endfunction

  task automatic apply(input int sz, input int lf, input int lg, input int a, input int n,
                       input int ci, input int xi);
    logic [DW+4:0] e;
    int w;
    @(negedge clk);
    size = 2'(sz); left = 1'(lf); logical = 1'(lg); opnd = DW'(a);
    cnt = CW'(n); cin = 1'(ci); xin = 1'(xi); upd = 1'b1;
    w = (sz == 0) ? DW/4 : (sz == 1) ? DW/2 : DW;
    e = model(sz, lf, lg, a, n, ci, xi);
    #1;
    // R2 result width confinement, R11 flags derived from it
    check((sz == 3) ? "R2" : req_of(lf, lg, n, w), {res, 5'b0}, {e[DW+4:5], 5'b0});
    @(posedge clk); #1;
    check((n != 0) ? "R10/R11" : "R3/R11", {DW'(0), fn, fz, fv, fc, fx}, {DW'(0), e[4:0]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] held;
    rst = 1'b1; upd = 1'b0; opnd = '0; cnt = '0; size = '0;
    left = 1'b0; logical = 1'b0; cin = 1'b1; xin = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset clears flags
    check("R12", {DW'(0), fn, fz, fv, fc, fx}, '0);
    @(negedge clk); rst = 1'b0;

    // Exhaustive sweep: sizes (R2), directions and types, every operand and count (R1).
    for (int sz = 0; sz < 4; sz++)
      for (int op = 0; op < 4; op++)
        for (int a = 0; a < (1 << DW); a++)
          for (int n = 0; n < (1 << CW); n++)
            apply(sz, op >> 1, op & 1, a, n, (a ^ n) & 1, ((a >> 1) ^ n) & 1);

    // R12 hold: strobe low, new inputs, flags keep last loaded value.
    apply(2, 1, 0, 8'h40, 1, 0, 0);
    held = {fn, fz, fv, fc, fx};
    @(negedge clk);
    upd = 1'b0; opnd = 8'h00; cnt = '0; cin = 1'b0; xin = 1'b1; left = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R12", {DW'(0), fn, fz, fv, fc, fx}, {DW'(0), held});
    // R12 reset after activity
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R12", {DW'(0), fn, fz, fv, fc, fx}, '0);
    @(negedge clk); rst = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule